// File: doc/BRIEF.md
# Indirect Oscillator Configuration Engine

This block gives software indirect access to a small bank of oscillator-frequency words through four registers. Software first loads an outbound data register. It then writes a packed control word that names a target word (device index), a function code and a direction, with a start bit set. The engine runs the transfer over a fixed, parameterized number of cycles. It then reports completion, and any error, in a status register. A read places the selected word in a return-data register. A write copies the outbound data into the selected word.

The word bank is always visible on a flat output bus, so the downstream clock generators can follow it. Each word starts from its own parameterized reset value. A transfer is valid only for function code 1 and a device index below the number of words. Any other request finishes with an error and changes no state. While a transfer is in flight the engine is busy, and it accepts no register writes.

Top module: `cfgch_engine`

## Requirements
- R1: After reset the control register reads 0x00100000, the status register and both data registers read 0, and oscillator word i holds its parameterized reset value.
- R2: A control write keeps device index bits [11:0], function bits [25:20] and direction bit 30 (1 = write). Reserved bits [19:12] and [29:26], and the start bit 31, are stored as 0 and read back as 0.
- R3: Any control write accepted while idle clears the status register from the next cycle, whether or not bit 31 is set. Status bit 0 is DONE and bit 1 is ERROR. All other status bits read 0.
- R4: A control write with bit 31 set, accepted while idle, drives busy high for exactly LATENCY cycles, and status reads 0 during that time. In the cycle busy falls, DONE reads 1.
- R5: A transfer whose function code is not 1, or whose 12-bit device index is not below NUM_OSC, sets both DONE and ERROR (status = 3). It changes neither the oscillator words nor the return-data register.
- R6: A valid write transfer copies the outbound data register into the oscillator word named by the device index, at completion.
- R7: A valid read transfer loads the selected oscillator word into the return-data register, at completion.
- R8: While busy, writes to the control register and the outbound data register are ignored, including any further start request.
- R9: Register offsets are: return data 0xA0 (read only), outbound data 0xA4, control 0xA8, status 0xAC (read only). All other offsets read 0, and writes to them have no effect.
- R10: osc_freq bits [32i+31:32i] carry oscillator word i, and these bits change only in the cycle in which a transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe for the current cycle |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| busy | output | 1 | A transfer is in flight |
| osc_freq | output | 32*NUM_OSC | Flat oscillator word bank |

## Verification
The hardest case to reach is a register write that arrives while a transfer is in flight. To get there, the stimulus issues a read transfer and, within its LATENCY-cycle window, writes both new outbound data and a second start request carrying a write direction. After completion the bench confirms three things: the data register still holds its old value, the control word still holds the first request, and busy does not rise again. Error cases use both a wrong function code and device indices just past the bank and at the 12-bit maximum. These show that the check covers the full index field and not only the bits that address the bank.

// File: rtl/cfgch_pkg.sv
package cfgch_pkg;
    localparam int DATA_W = 32;

    localparam logic [11:0] OFS_RTN  = 12'h0A0;
    localparam logic [11:0] OFS_DOUT = 12'h0A4;
    localparam logic [11:0] OFS_CTRL = 12'h0A8;
    localparam logic [11:0] OFS_STAT = 12'h0AC;

    localparam int DEV_LSB  = 0;
    localparam int DEV_W    = 12;
    localparam int FUNC_LSB = 20;
    localparam int FUNC_W   = 6;
    localparam int DIR_BIT  = 30;
    localparam int GO_BIT   = 31;

    localparam logic [DATA_W-1:0] CTRL_KEEP  = 32'h43F0_0FFF;
    localparam logic [DATA_W-1:0] CTRL_RESET = 32'h0010_0000;
    localparam logic [FUNC_W-1:0] FUNC_OSC   = 6'd1;

    typedef struct packed {
        logic             dir_wr;
        logic [FUNC_W-1:0] func;
        logic [DEV_W-1:0]  dev;
    } ctrl_fields_t;

    function automatic ctrl_fields_t unpack_ctrl(input logic [DATA_W-1:0] w);
        ctrl_fields_t f;
        f.dir_wr = w[DIR_BIT];
        f.func   = w[FUNC_LSB +: FUNC_W];
        f.dev    = w[DEV_LSB +: DEV_W];
        return f;
    endfunction
endpackage

// File: rtl/cfgch_access_check.sv
module cfgch_access_check #(
    parameter int NUM_OSC = 3,
    localparam int IDX_W  = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1
) (
    input  logic [cfgch_pkg::DEV_W-1:0]  dev,
    input  logic [cfgch_pkg::FUNC_W-1:0] func,
    output logic                         ok,
    output logic [IDX_W-1:0]             idx
);
    always_comb begin
        ok  = (func == cfgch_pkg::FUNC_OSC) && (32'(dev) < NUM_OSC);
        idx = dev[IDX_W-1:0];
    end
endmodule

// File: rtl/cfgch_osc_bank.sv
module cfgch_osc_bank #(
    parameter int NUM_OSC = 3,
    parameter logic [32*NUM_OSC-1:0] OSC_RESET = '0,
    localparam int IDX_W = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [31:0]            wr_data,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [31:0]            rd_data,
    output logic [32*NUM_OSC-1:0]  words
);
    logic [31:0] word_q [NUM_OSC];

    for (genvar g = 0; g < NUM_OSC; g++) begin : g_word
        logic [31:0] word_d;
        always_comb begin
            word_d = word_q[g];
            if (wr_en && (32'(wr_idx) == g)) word_d = wr_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q[g] <= OSC_RESET[32*g +: 32];
            else        word_q[g] <= word_d;
        end
        assign words[32*g +: 32] = word_q[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_OSC; i++)
            if (32'(rd_idx) == i) rd_data = word_q[i];
    end
endmodule

// File: rtl/cfgch_read_mux.sv
module cfgch_read_mux #(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       rtn,
    input  logic [31:0]       dout,
    input  logic [31:0]       ctrl,
    input  logic [1:0]        stat,
    output logic [31:0]       rdata
);
    always_comb begin
        unique case (addr)
            ADDR_W'(cfgch_pkg::OFS_RTN):  rdata = rtn;
            ADDR_W'(cfgch_pkg::OFS_DOUT): rdata = dout;
            ADDR_W'(cfgch_pkg::OFS_CTRL): rdata = ctrl;
            ADDR_W'(cfgch_pkg::OFS_STAT): rdata = {30'b0, stat};
            default:                      rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfgch_engine.sv
module cfgch_engine #(
    parameter int NUM_OSC = 3,
    parameter int LATENCY = 4,
    parameter int ADDR_W  = 12,
    parameter logic [32*NUM_OSC-1:0] OSC_RESET = {32'd25_000_000, 32'd24_576_000, 32'd50_000_000}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic                  busy,
    output logic [32*NUM_OSC-1:0] osc_freq
);
    import cfgch_pkg::*;

    localparam int IDX_W = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1;
    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

    typedef struct packed {
        logic [31:0]      rtn;
        logic [31:0]      dout;
        logic [31:0]      ctrl;
        logic             done;
        logic             err;
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t       st_d, st_q;
    ctrl_fields_t fld;
    logic         acc_ok;
    logic [IDX_W-1:0] acc_idx;
    logic         osc_we;
    logic [31:0]  osc_rd;
    logic         wr_dout, wr_ctrl;

    assign fld = unpack_ctrl(st_q.ctrl);

    cfgch_access_check #(.NUM_OSC(NUM_OSC)) u_chk_acc (
        .dev  (fld.dev),
        .func (fld.func),
        .ok   (acc_ok),
        .idx  (acc_idx)
    );

    cfgch_osc_bank #(.NUM_OSC(NUM_OSC), .OSC_RESET(OSC_RESET)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (osc_we),
        .wr_idx  (acc_idx),
        .wr_data (st_q.dout),
        .rd_idx  (acc_idx),
        .rd_data (osc_rd),
        .words   (osc_freq)
    );

    cfgch_read_mux #(.ADDR_W(ADDR_W)) u_rmux (
        .addr  (reg_addr),
        .rtn   (st_q.rtn),
        .dout  (st_q.dout),
        .ctrl  (st_q.ctrl),
        .stat  ({st_q.err, st_q.done}),
        .rdata (reg_rdata)
    );

    assign wr_dout = reg_wr && (reg_addr == ADDR_W'(OFS_DOUT));
    assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));

    always_comb begin
        st_d   = st_q;
        osc_we = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.err  = !acc_ok;
                osc_we    = acc_ok && fld.dir_wr;
                if (acc_ok && !fld.dir_wr) st_d.rtn = osc_rd;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else begin
            if (wr_dout) st_d.dout = reg_wdata;
            if (wr_ctrl) begin
                st_d.ctrl = reg_wdata & CTRL_KEEP;
                st_d.done = 1'b0;
                st_d.err  = 1'b0;
                if (reg_wdata[GO_BIT]) begin
                    st_d.busy = 1'b1;
                    st_d.cnt  = CNT_W'(LATENCY - 1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ctrl <= CTRL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
endmodule

// File: rtl/cfgch_chk.sv
module cfgch_chk #(
    parameter int NUM_OSC = 3,
    parameter int LATENCY = 4,
    parameter int ADDR_W  = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic [31:0]           reg_wdata,
    input logic [31:0]           reg_rdata,
    input logic                  busy,
    input logic [32*NUM_OSC-1:0] osc_freq
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(cfgch_pkg::OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(cfgch_pkg::OFS_STAT);

    int busy_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    assert_ctrl_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CTRL) |-> ((reg_rdata & ~cfgch_pkg::CTRL_KEEP) == 32'h0));

    assert_stat_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_STAT) |-> (reg_rdata[31:2] == 30'h0));

    assert_clear_on_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && !busy) |=> (reg_addr != A_STAT || reg_rdata == 32'h0));

    assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && reg_wdata[31] && !busy) |=> busy);

    assert_no_done_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_addr == A_STAT) |-> (reg_rdata[0] == 1'b0));

    assert_busy_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= LATENCY);

    assert_osc_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> $stable(osc_freq));
endmodule

bind cfgch_engine cfgch_chk #(.NUM_OSC(NUM_OSC), .LATENCY(LATENCY), .ADDR_W(ADDR_W)) u_cfgch_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .osc_freq  (osc_freq)
);

// File: tb/tb_cfgch_engine.sv
`timescale 1ns/1ps
module tb_cfgch_engine;
    localparam int NUM_OSC = 3;
    localparam int LATENCY = 4;
    localparam int ADDR_W  = 12;
    localparam logic [32*NUM_OSC-1:0] RST_WORDS = {32'h0BEE_F003, 32'h0AAA_0002, 32'h0555_0001};

    localparam logic [11:0] A_RTN = 12'h0A0, A_DOUT = 12'h0A4, A_CTRL = 12'h0A8, A_STAT = 12'h0AC;

    logic clk = 0, rst_n = 0, reg_wr = 0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic busy;
    logic [32*NUM_OSC-1:0] osc_freq;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cfgch_engine #(.NUM_OSC(NUM_OSC), .LATENCY(LATENCY), .ADDR_W(ADDR_W), .OSC_RESET(RST_WORDS)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .osc_freq(osc_freq)
    );

    // behavioural reference
    int unsigned m_rtn, m_dout, m_ctrl, m_stat, m_cnt;
    int unsigned m_osc[NUM_OSC];
    bit m_busy;

    function automatic int unsigned m_read(input logic [ADDR_W-1:0] a);
        case (a)
            A_RTN:  return m_rtn;
            A_DOUT: return m_dout;
            A_CTRL: return m_ctrl;
            A_STAT: return m_stat;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rtn = 0; m_dout = 0; m_ctrl = 32'h0010_0000; m_stat = 0; m_busy = 0; m_cnt = 0;
            for (int i = 0; i < NUM_OSC; i++) m_osc[i] = RST_WORDS[32*i +: 32];
        end else if (m_busy) begin
            if (m_cnt > 1) m_cnt--;
            else begin
                int unsigned dev, fn;
                bit good;
                dev  = m_ctrl % 4096;
                fn   = (m_ctrl / (1 << 20)) % 64;
                good = (fn == 1) && (dev < NUM_OSC);
                m_busy = 0;
                m_stat = good ? 1 : 3;
                if (good) begin
                    if ((m_ctrl / (1 << 30)) % 2 == 1) m_osc[dev] = m_dout;
                    else m_rtn = m_osc[dev];
                end
            end
        end else if (reg_wr) begin
            if (reg_addr == A_DOUT) m_dout = reg_wdata;
            if (reg_addr == A_CTRL) begin
                m_ctrl = reg_wdata & 32'h43F0_0FFF;
                m_stat = 0;
                if (reg_wdata[31]) begin m_busy = 1; m_cnt = LATENCY; end
            end
        end
    end

    always @(negedge clk) if (rst_n && !finished) begin
        n_cmp++;
        if (busy !== m_busy) begin n_bad++; $display("FAIL R4 busy act=%0b exp=%0b", busy, m_busy); end
        n_cmp++;
        if (reg_rdata !== m_read(reg_addr)) begin
            n_bad++; $display("FAIL R9 rdata@%h act=%h exp=%h", reg_addr, reg_rdata, m_read(reg_addr));
        end
        for (int i = 0; i < NUM_OSC; i++) begin
            n_cmp++;
            if (osc_freq[32*i +: 32] !== m_osc[i]) begin
                n_bad++; $display("FAIL R6 osc%0d act=%h exp=%h", i, osc_freq[32*i +: 32], m_osc[i]);
            end
        end
    end

    // stimulus helpers: each starts and ends just after a rising edge
    task automatic step(); @(posedge clk); #1; endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1; step(); reg_wr = 0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin n_bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        reg_addr = a; @(negedge clk); chk(tag, reg_rdata, exp); step();
    endtask

    task automatic run_txn(input logic [31:0] c);
        wr_reg(A_CTRL, c); repeat (LATENCY) step();
    endtask

    function automatic logic [31:0] cw(input bit go, input bit w, input int fn, input int dev);
        return {go, w, 4'b0, 6'(fn), 8'b0, 12'(dev)};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        step();
        // R1 reset state
        rd_chk("R1 ctrl", A_CTRL, 32'h0010_0000);
        rd_chk("R1 stat", A_STAT, 0);
        rd_chk("R1 rtn",  A_RTN,  0);
        rd_chk("R1 dout", A_DOUT, 0);
        for (int i = 0; i < NUM_OSC; i++) chk("R1 osc", osc_freq[32*i +: 32], RST_WORDS[32*i +: 32]);
        // R9 unmapped offsets
        wr_reg(12'h000, 32'hFFFF_FFFF);
        rd_chk("R9 unmapped", 12'h000, 0);
        wr_reg(A_RTN, 32'h1234_5678);
        rd_chk("R9 rtn read-only", A_RTN, 0);
        // R7 valid read with busy window (R4)
        wr_reg(A_CTRL, cw(1, 0, 1, 1));
        reg_addr = A_STAT;
        @(negedge clk); chk("R4 busy high", busy, 1); chk("R4 done low", reg_rdata, 0); step();
        for (int k = 1; k < LATENCY; k++) begin
            @(negedge clk); chk("R4 busy hold", busy, 1); step();
        end
        @(negedge clk); chk("R4 busy fell", busy, 0); chk("R4 done", reg_rdata, 1); step();
        rd_chk("R7 rtn", A_RTN, RST_WORDS[63:32]);
        rd_chk("R2 start reads 0", A_CTRL, cw(0, 0, 1, 1));
        // R6 valid write
        wr_reg(A_DOUT, 32'hCAFE_0123);
        run_txn(cw(1, 1, 1, 2));
        rd_chk("R6 stat", A_STAT, 1);
        chk("R6 osc2", osc_freq[95:64], 32'hCAFE_0123);
        chk("R10 osc0 untouched", osc_freq[31:0], RST_WORDS[31:0]);
        run_txn(cw(1, 0, 1, 2));
        rd_chk("R7 rtn word2", A_RTN, 32'hCAFE_0123);
        // R5 bad function
        run_txn(cw(1, 0, 2, 0));
        rd_chk("R5 badfn stat", A_STAT, 3);
        rd_chk("R5 rtn kept", A_RTN, 32'hCAFE_0123);
        // R5 device out of range
        wr_reg(A_DOUT, 32'h5555_AAAA);
        run_txn(cw(1, 1, 1, NUM_OSC));
        rd_chk("R5 range stat", A_STAT, 3);
        chk("R5 osc0 kept", osc_freq[31:0], RST_WORDS[31:0]);
        chk("R5 osc2 kept", osc_freq[95:64], 32'hCAFE_0123);
        run_txn(cw(1, 1, 1, 12'hFFF));
        rd_chk("R5 maxdev stat", A_STAT, 3);
        chk("R5 osc1 kept", osc_freq[63:32], RST_WORDS[63:32]);
        // R3 control write without start
        wr_reg(A_CTRL, 32'h4010_0001);
        @(negedge clk); chk("R3 no busy", busy, 0); step();
        rd_chk("R3 stat cleared", A_STAT, 0);
        rd_chk("R2 ctrl kept", A_CTRL, 32'h4010_0001);
        wr_reg(A_CTRL, 32'h3FFF_F005);
        rd_chk("R2 reserved masked", A_CTRL, 32'h03F0_0005);
        // R8 writes during busy ignored
        wr_reg(A_CTRL, cw(1, 0, 1, 0));
        wr_reg(A_DOUT, 32'h1111_1111);
        wr_reg(A_CTRL, cw(1, 1, 1, 1));
        repeat (LATENCY - 2) step();
        @(negedge clk); chk("R8 done", busy, 0); step();
        @(negedge clk); chk("R8 no restart", busy, 0); step();
        rd_chk("R8 dout kept", A_DOUT, 32'h5555_AAAA);
        rd_chk("R8 ctrl kept", A_CTRL, cw(0, 0, 1, 0));
        rd_chk("R8 rtn word0", A_RTN, RST_WORDS[31:0]);
        chk("R8 osc1 kept", osc_freq[63:32], RST_WORDS[63:32]);
        repeat (3) step();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule